// File: doc/BRIEF.md
# Branch Condition and Target Unit

This unit sits in the issue stage of a 32-bit core and resolves control flow for two instruction kinds. For a conditional branch it selects one of the condition tests, evaluates it against flags held elsewhere, and works out the destination. The destination is either an absolute word address taken from an immediate, or a base register value plus a scaled offset. For a set-on-condition instruction it evaluates the same test and produces a 0/1 value for the register file.

The unit owns the program counter. Every issued instruction advances it by one word. A branch always has one delay slot: the instruction after the branch is issued before any redirect takes effect. A branch issued inside a delay slot is illegal. It is flagged and then ignored.

Each condition is a 3-bit code plus an inversion bit. The unsigned tests read the carry flag as "no borrow". The signed tests read four precomputed pseudo-flags rather than deriving them here.

Top module: `branch_cond_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `pc_o` equals `RESET_PC` and `br_taken_o`, `br_target_o`, `setc_we_o`, `setc_val_o` and `dslot_err_o` are all zero.
- R2: The unsigned and equality tests are decoded as follows, with `cond_inv_i` choosing the second meaning:
  - code 3'b001: C&!Z, or !C|Z when inverted.
  - code 3'b010: !C, or C when inverted.
  - code 3'b011: !Z, or Z when inverted.
- R3: The remaining tests are decoded as follows:
  - code 3'b000: always true, or always false when inverted.
  - code 3'b101: !N, or N when inverted.
  - code 3'b110: the ge pseudo-flag, or the lt pseudo-flag when inverted.
  - code 3'b111: the gt pseudo-flag, or the le pseudo-flag when inverted.
  - code 3'b100: false for either value of the inversion bit.
- R4: With `rel_i`=0 the target is `abs_dst_i` shifted left by 2 and zero-extended to 32 bits.
- R5: With `rel_i`=1 the target is `base_i` plus `rel_off_i` zero-extended and shifted left by 2, taken modulo 2^32.
- R6: `op_i` encodes the instruction kind: 2'b01 is a branch, 2'b10 is set-on-condition, and any other value is a plain instruction. One cycle after a set-on-condition is issued, `setc_we_o` pulses high and `setc_val_o` holds the condition result in bit 0 with all upper bits zero. `setc_val_o` keeps its value at other times.
- R7: Each cycle with `issue_i` high outside a delay slot advances `pc_o` by 4 on the next edge. With `issue_i` low, `pc_o` and the delay-slot state hold.
- R8: After a taken branch, `pc_o` moves to the branch pc plus 4, so the delay slot is issued. Once the delay-slot instruction has issued, `pc_o` becomes the target.
- R9: After a branch whose condition is false, `pc_o` keeps stepping by 4 through and past the delay slot.
- R10: A branch issued in a delay slot makes `dslot_err_o` pulse one cycle later. That branch has no effect on `pc_o`, `br_taken_o` or `br_target_o`, and the earlier branch's redirect still applies.
- R11: One cycle after a legal branch issues, `br_taken_o` shows its condition result and `br_target_o` its target. Otherwise `br_taken_o` is 0 and `br_target_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | An instruction is issued at `pc_o` this cycle |
| op_i | input | 2 | Instruction kind: 01 branch, 10 set-on-condition, other plain |
| cond_i | input | 3 | Condition code |
| cond_inv_i | input | 1 | Condition inversion bit |
| rel_i | input | 1 | 1 selects the register-relative target form |
| abs_dst_i | input | ABS_W | Absolute destination word field |
| rel_off_i | input | REL_W | Relative offset word field |
| base_i | input | AW | Base register value for the relative form |
| flag_z_i | input | 1 | Zero flag |
| flag_n_i | input | 1 | Negative flag |
| flag_c_i | input | 1 | Carry (no-borrow) flag |
| flag_ge_i | input | 1 | Signed greater-or-equal pseudo-flag |
| flag_lt_i | input | 1 | Signed less-than pseudo-flag |
| flag_gt_i | input | 1 | Signed greater-than pseudo-flag |
| flag_le_i | input | 1 | Signed less-or-equal pseudo-flag |
| pc_o | output | AW | Program counter of the next instruction to issue |
| br_taken_o | output | 1 | Legal branch issued last cycle was taken |
| br_target_o | output | AW | Target of the last legal branch |
| setc_we_o | output | 1 | Set-on-condition register write strobe |
| setc_val_o | output | AW | Set-on-condition value, zero-extended |
| dslot_err_o | output | 1 | A branch was issued in a delay slot |

## Verification
The instruction in a delay slot can collide with two other events in the same cycle. One is the pending redirect of `pc_o` being applied. The other is either a set-on-condition write or an illegal-branch error. The bench provokes both cases with directed sequences: a set-on-condition placed in the slot of a taken branch, and a taken branch placed in the slot of another. It judges them by checking in the following cycle that the pc went to the first target and that the write value or error pulse appeared alongside. A long stretch of random operations, flags and issue gaps then hits these overlaps again. Throughout, a behavioural model is compared against every output each clock.

// File: rtl/branch_cond_pkg.sv
package branch_cond_pkg;

  typedef enum logic [1:0] {
    OP_PLAIN  = 2'b00,
    OP_BRANCH = 2'b01,
    OP_SETC   = 2'b10,
    OP_OTHER  = 2'b11
  } op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic ge;
    logic lt;
    logic gt;
    logic le;
  } flags_t;

  localparam logic [2:0] CC_TRUE = 3'b000;
  localparam logic [2:0] CC_UGT  = 3'b001;
  localparam logic [2:0] CC_ULT  = 3'b010;
  localparam logic [2:0] CC_NE   = 3'b011;
  localparam logic [2:0] CC_RSVD = 3'b100;
  localparam logic [2:0] CC_PL   = 3'b101;
  localparam logic [2:0] CC_GE   = 3'b110;
  localparam logic [2:0] CC_GT   = 3'b111;

endpackage

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
  import branch_cond_pkg::*;
(
  input  logic [2:0] code_i,
  input  logic       inv_i,
  input  flags_t     flags_i,
  output logic       hit_o
);

  always_comb begin
    unique case (code_i)
      CC_TRUE: hit_o = ~inv_i;
      CC_UGT:  hit_o = inv_i ? (~flags_i.c | flags_i.z) : (flags_i.c & ~flags_i.z);
      CC_ULT:  hit_o = inv_i ? flags_i.c : ~flags_i.c;
      CC_NE:   hit_o = inv_i ? flags_i.z : ~flags_i.z;
      CC_RSVD: hit_o = 1'b0;
      CC_PL:   hit_o = inv_i ? flags_i.n : ~flags_i.n;
      CC_GE:   hit_o = inv_i ? flags_i.lt : flags_i.ge;
      CC_GT:   hit_o = inv_i ? flags_i.le : flags_i.gt;
      default: hit_o = 1'b0;
    endcase
  end

  // R3: true code with no inversion is always taken
  always_comb begin
    if (code_i == CC_TRUE && !inv_i)
      a_r3_true_hits: assert (hit_o);
  end

endmodule

// File: rtl/branch_target_gen.sv
module branch_target_gen #(
  parameter int AW    = 32,
  parameter int ABS_W = 23,
  parameter int REL_W = 14
) (
  input  logic             rel_i,
  input  logic [ABS_W-1:0] abs_dst_i,
  input  logic [REL_W-1:0] rel_off_i,
  input  logic [AW-1:0]    base_i,
  output logic [AW-1:0]    target_o
);

  localparam int ABS_TOP = ABS_W + 1;
  localparam int REL_TOP = REL_W + 1;

  logic [AW-1:0] abs_ext;
  logic [AW-1:0] off_ext;

  generate
    if (ABS_TOP < AW) begin : g_abs_pad
      assign abs_ext = {{(AW-ABS_TOP-1){1'b0}}, abs_dst_i, 2'b00};
    end else begin : g_abs_cut
      assign abs_ext = {abs_dst_i[AW-3:0], 2'b00};
    end
    if (REL_TOP < AW) begin : g_rel_pad
      assign off_ext = {{(AW-REL_TOP-1){1'b0}}, rel_off_i, 2'b00};
    end else begin : g_rel_cut
      assign off_ext = {rel_off_i[AW-3:0], 2'b00};
    end
  endgenerate

  assign target_o = rel_i ? (base_i + off_ext) : abs_ext;

endmodule

// File: rtl/branch_pc_seq.sv
module branch_pc_seq #(
  parameter int            AW       = 32,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue_i,
  input  logic          is_branch_i,
  input  logic          hit_i,
  input  logic [AW-1:0] target_i,
  output logic [AW-1:0] pc_o,
  output logic          in_slot_o,
  output logic          err_o
);

  localparam logic [AW-1:0] STEP = AW'(4);

  logic [AW-1:0] pc_q;
  logic [AW-1:0] tgt_q;
  logic          slot_q;
  logic          redir_q;
  logic          err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= RESET_PC;
      tgt_q   <= '0;
      slot_q  <= 1'b0;
      redir_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (issue_i) begin
        if (slot_q) begin
          pc_q    <= redir_q ? tgt_q : pc_q + STEP;
          slot_q  <= 1'b0;
          redir_q <= 1'b0;
          err_q   <= is_branch_i;
        end else begin
          pc_q <= pc_q + STEP;
          if (is_branch_i) begin
            slot_q  <= 1'b1;
            redir_q <= hit_i;
            tgt_q   <= target_i;
          end
        end
      end
    end
  end

  assign pc_o      = pc_q;
  assign in_slot_o = slot_q;
  assign err_o     = err_q;

  // R7: sequential step outside a delay slot
  a_r7_step: assert property (@(posedge clk) disable iff (rst)
    issue_i && !slot_q |=> pc_q == $past(pc_q) + STEP);

  // R7: no issue, no movement
  a_r7_stall: assert property (@(posedge clk) disable iff (rst)
    !issue_i |=> $stable(pc_q) && $stable(slot_q));

  // R8: delay slot of a taken branch redirects to the stored target
  a_r8_redirect: assert property (@(posedge clk) disable iff (rst)
    issue_i && slot_q && redir_q |=> pc_q == $past(tgt_q));

  // R10: an error pulse always closes the slot
  a_r10_err_closes: assert property (@(posedge clk) disable iff (rst)
    err_q |-> !slot_q);

endmodule

// File: rtl/branch_cond_unit.sv
module branch_cond_unit
  import branch_cond_pkg::*;
#(
  parameter int            AW       = 32,
  parameter int            ABS_W    = 23,
  parameter int            REL_W    = 14,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_i,
  input  logic [1:0]       op_i,
  input  logic [2:0]       cond_i,
  input  logic             cond_inv_i,
  input  logic             rel_i,
  input  logic [ABS_W-1:0] abs_dst_i,
  input  logic [REL_W-1:0] rel_off_i,
  input  logic [AW-1:0]    base_i,
  input  logic             flag_z_i,
  input  logic             flag_n_i,
  input  logic             flag_c_i,
  input  logic             flag_ge_i,
  input  logic             flag_lt_i,
  input  logic             flag_gt_i,
  input  logic             flag_le_i,
  output logic [AW-1:0]    pc_o,
  output logic             br_taken_o,
  output logic [AW-1:0]    br_target_o,
  output logic             setc_we_o,
  output logic [AW-1:0]    setc_val_o,
  output logic             dslot_err_o
);

  flags_t        flags;
  logic          hit;
  logic [AW-1:0] target;
  logic          is_branch;
  logic          is_setc;
  logic          in_slot;

  assign flags     = '{z: flag_z_i, n: flag_n_i, c: flag_c_i,
                       ge: flag_ge_i, lt: flag_lt_i, gt: flag_gt_i, le: flag_le_i};
  assign is_branch = (op_i == OP_BRANCH);
  assign is_setc   = (op_i == OP_SETC);

  branch_cond_eval u_eval (
    .code_i  (cond_i),
    .inv_i   (cond_inv_i),
    .flags_i (flags),
    .hit_o   (hit)
  );

  branch_target_gen #(.AW(AW), .ABS_W(ABS_W), .REL_W(REL_W)) u_tgt (
    .rel_i     (rel_i),
    .abs_dst_i (abs_dst_i),
    .rel_off_i (rel_off_i),
    .base_i    (base_i),
    .target_o  (target)
  );

  branch_pc_seq #(.AW(AW), .RESET_PC(RESET_PC)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .issue_i     (issue_i),
    .is_branch_i (is_branch),
    .hit_i       (hit),
    .target_i    (target),
    .pc_o        (pc_o),
    .in_slot_o   (in_slot),
    .err_o       (dslot_err_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      br_taken_o  <= 1'b0;
      br_target_o <= '0;
      setc_we_o   <= 1'b0;
      setc_val_o  <= '0;
    end else begin
      br_taken_o <= 1'b0;
      setc_we_o  <= 1'b0;
      if (issue_i && is_branch && !in_slot) begin
        br_taken_o  <= hit;
        br_target_o <= target;
      end
      if (issue_i && is_setc) begin
        setc_we_o  <= 1'b1;
        setc_val_o <= {{(AW-1){1'b0}}, hit};
      end
    end
  end

  // R6: written value is a zero-extended single bit
  a_r6_setc_zext: assert property (@(posedge clk) disable iff (rst)
    setc_we_o |-> setc_val_o[AW-1:1] == '0);

  // R10: an illegal branch never reports as taken
  a_r10_err_not_taken: assert property (@(posedge clk) disable iff (rst)
    dslot_err_o |-> !br_taken_o);

  // R6: write strobe only follows an issued set-on-condition
  a_r6_we_follows_issue: assert property (@(posedge clk) disable iff (rst)
    setc_we_o |-> $past(issue_i) && $past(op_i) == OP_SETC);

endmodule

// File: tb/branch_cond_unit_tb.sv
`timescale 1ns/1ps
module branch_cond_unit_tb;

  localparam logic [31:0] RPC = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst;
  logic        issue;
  logic [1:0]  op;
  logic [2:0]  cc;
  logic        inv;
  logic        rel;
  logic [22:0] dst;
  logic [13:0] off;
  logic [31:0] base;
  logic        fz, fn, fc, fge, flt, fgt, fle;
  logic [31:0] pc, btgt, sval;
  logic        taken, swe, err;

  int n_chk = 0;
  int n_bad = 0;

  // model state
  logic [31:0] m_pc, m_tgt, m_btgt, m_sval;
  logic        m_slot, m_redir, m_err, m_taken, m_we;

  always #5 clk = ~clk;

  branch_cond_unit #(.RESET_PC(RPC)) u_dut (
    .clk(clk), .rst(rst), .issue_i(issue), .op_i(op), .cond_i(cc),
    .cond_inv_i(inv), .rel_i(rel), .abs_dst_i(dst), .rel_off_i(off),
    .base_i(base), .flag_z_i(fz), .flag_n_i(fn), .flag_c_i(fc),
    .flag_ge_i(fge), .flag_lt_i(flt), .flag_gt_i(fgt), .flag_le_i(fle),
    .pc_o(pc), .br_taken_o(taken), .br_target_o(btgt),
    .setc_we_o(swe), .setc_val_o(sval), .dslot_err_o(err)
  );

  function automatic bit m_cond();
    case (cc)
      3'd0: return !inv;
      3'd1: return inv ? (!fc || fz) : (fc && !fz);
      3'd2: return inv ? fc : !fc;
      3'd3: return inv ? fz : !fz;
      3'd5: return inv ? fn : !fn;
      3'd6: return inv ? flt : fge;
      3'd7: return inv ? fle : fgt;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] m_target();
    if (rel) return base + {16'd0, off, 2'b00};
    return {7'd0, dst, 2'b00};
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "pc", pc, m_pc);
    chk(tag, "taken", {31'd0, taken}, {31'd0, m_taken});
    chk(tag, "target", btgt, m_btgt);
    chk(tag, "we", {31'd0, swe}, {31'd0, m_we});
    chk(tag, "setval", sval, m_sval);
    chk(tag, "err", {31'd0, err}, {31'd0, m_err});
  endtask

  // one clock: advance the model with the inputs held across the edge
  task automatic tick(string tag);
    bit h;
    logic [31:0] t;
    @(posedge clk);
    h = m_cond();
    t = m_target();
    if (rst) begin
      m_pc = RPC; m_tgt = 0; m_btgt = 0; m_sval = 0;
      m_slot = 0; m_redir = 0; m_err = 0; m_taken = 0; m_we = 0;
    end else begin
      m_err = 0; m_taken = 0; m_we = 0;
      if (issue && op == 2'b10) begin m_we = 1; m_sval = {31'd0, h}; end
      if (issue) begin
        if (m_slot) begin
          m_err = (op == 2'b01);
          m_pc = m_redir ? m_tgt : m_pc + 4;
          m_slot = 0; m_redir = 0;
        end else begin
          m_pc = m_pc + 4;
          if (op == 2'b01) begin
            m_slot = 1; m_redir = h; m_tgt = t;
            m_taken = h; m_btgt = t;
          end
        end
      end
    end
    #2;
    compare(tag);
  endtask

  task automatic set_in(logic i, logic [1:0] o, logic [2:0] c, logic v, logic r,
                        logic [22:0] d, logic [13:0] f, logic [31:0] b);
    issue = i; op = o; cc = c; inv = v; rel = r; dst = d; off = f; base = b;
  endtask

  task automatic set_flags(logic [6:0] f);
    {fz, fn, fc, fge, flt, fgt, fle} = f;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst = 1;
    set_in(0, 0, 0, 0, 0, 0, 0, 0);
    set_flags(0);
    tick("R1"); tick("R1");
    rst = 0;
    set_in(0, 0, 0, 0, 0, 0, 0, 0);
    tick("R1");

    // R7: plain issue and stall
    set_in(1, 2'b00, 0, 0, 0, 0, 0, 0); tick("R7"); tick("R7");
    set_in(0, 2'b00, 0, 0, 0, 0, 0, 0); tick("R7"); tick("R7");
    set_in(1, 2'b11, 0, 0, 0, 0, 0, 0); tick("R7");

    // R2 / R3: full condition table through set-on-condition
    for (int c = 0; c < 8; c++)
      for (int v = 0; v < 2; v++)
        for (int f = 0; f < 128; f += 19) begin
          set_flags(7'(f));
          set_in(1, 2'b10, 3'(c), v[0], 0, 0, 0, 0);
          tick((c == 1 || c == 2 || c == 3) ? "R2" : "R3");
        end
    set_flags(7'b1111111);
    set_in(1, 2'b10, 3'd4, 0, 0, 0, 0, 0); tick("R3");
    set_in(1, 2'b10, 3'd4, 1, 0, 0, 0, 0); tick("R3");
    set_in(1, 2'b00, 0, 0, 0, 0, 0, 0); tick("R6"); // value holds

    // R4: absolute taken branch, then delay slot, then redirect
    set_in(1, 2'b01, 3'd0, 0, 0, 23'h7F_FFFF, 0, 0); tick("R4");
    set_in(1, 2'b00, 0, 0, 0, 0, 0, 0); tick("R8");
    tick("R8");

    // R5: relative with wrap, flags chosen for equal
    set_flags(7'b1000000);
    set_in(1, 2'b01, 3'd3, 1, 1, 0, 14'h3FFF, 32'hFFFF_FFF0); tick("R5");
    set_in(0, 2'b00, 0, 0, 0, 0, 0, 0); tick("R7");
    set_in(1, 2'b00, 0, 0, 0, 0, 0, 0); tick("R8");

    // R9: not taken
    set_in(1, 2'b01, 3'd3, 0, 0, 23'h123, 0, 0); tick("R9");
    set_in(1, 2'b00, 0, 0, 0, 0, 0, 0); tick("R9"); tick("R9");

    // R11 / R6 in slot: set-on-condition inside a taken branch's slot
    set_in(1, 2'b01, 3'd0, 0, 0, 23'h40, 0, 0); tick("R11");
    set_in(1, 2'b10, 3'd0, 0, 0, 0, 0, 0); tick("R6");

    // R10: branch in a delay slot
    set_in(1, 2'b01, 3'd0, 0, 0, 23'h80, 0, 0); tick("R10");
    set_in(1, 2'b01, 3'd0, 0, 0, 23'h99, 0, 0); tick("R10");
    set_in(1, 2'b00, 0, 0, 0, 0, 0, 0); tick("R10");

    // mixed random traffic
    for (int k = 0; k < 600; k++) begin
      set_flags(7'($urandom));
      set_in(($urandom_range(0, 9) < 8), 2'($urandom), 3'($urandom), 1'($urandom),
             1'($urandom), 23'($urandom), 14'($urandom), $urandom);
      tick("R8");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule